// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block holds the interrupt state of a UART-style peripheral. It latches the events reported by the receive path, the transmit path, the timeout logic and the error detectors into a raw status vector. It also tracks four modem-status input levels. A software-written enable mask selects which raw bits may raise interrupts. Six registered interrupt lines carry the enabled bits: one combined line and five grouped lines.

Software reaches the unit through a plain word-addressed register port. The port has three readable views (the mask, the raw status and the masked status), a writable mask, and a write-one-to-clear location. The bus protocol, the FIFOs and the serial shifter live elsewhere and drive this block only through single-cycle event pulses and level inputs.

Raw status bit positions are fixed, because other logic and software decode them. The modem bits are bits 0 to 3: RI is bit 0, CTS is bit 1, DCD is bit 2 and DSR is bit 3. Bit 4 is receive, bit 5 is transmit and bit 6 is receive timeout. The error bits are bits 7 to 10: framing is bit 7, parity is bit 8, break is bit 9 and overrun is bit 10.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Event pulses set raw bits as follows: `ev_rx_trig` sets bit 4, `ev_tx_write` sets bit 5 and `ev_rx_timeout` sets bit 6. `ev_err[0..3]` set bits 7 to 10 (framing, parity, break, overrun). The raw view reads at word address 1 and shows the bit in the cycle after the pulse.
- R2: The mask is at word address 0 and reads back the written value. The masked view at word address 2 always reads raw AND mask.
- R3: Read data bits 31..11 are always zero. A read of the clear location (word address 3) returns zero.
- R4: A write to word address 3 clears every raw bit that is 1 in the written data. Raw bits that are 0 in the written data are left unchanged.
- R5: Writes to word addresses 1 and 2 change neither the raw status nor the mask.
- R6: `irq[0]` is the OR of all masked bits. `irq[1]` is masked bit 4 and `irq[2]` is masked bit 5. `irq[3]` is masked bit 6, `irq[4]` is the OR of masked bits 0..3 and `irq[5]` is the OR of masked bits 7..10.
- R7: When `modem_lvl` differs from its previously seen value, raw bits 0..3 are rewritten to the new levels (`modem_lvl[0]`=RI, `[1]`=CTS, `[2]`=DCD, `[3]`=DSR). If a modem bit is cleared by software while its level is unchanged, the bit stays cleared until the next change.
- R8: If a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: While `rst_n` is low, the mask, the raw status and all interrupt lines are zero.
- R10: The interrupt lines are registered. They reflect the raw status and mask one clock after those registers change.
- R11: `ev_rx_below` clears raw bit 4. If `ev_rx_trig` is pulsed in the same cycle, bit 4 is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_trig | input | 1 | Receive fill reached trigger level (pulse) |
| ev_rx_below | input | 1 | Receive fill dropped below trigger level (pulse) |
| ev_tx_write | input | 1 | Data register was written (pulse) |
| ev_rx_timeout | input | 1 | Receive timeout (pulse) |
| ev_err | input | 4 | Error pulses: framing, parity, break, overrun |
| modem_lvl | input | 4 | Modem-status levels: RI, CTS, DCD, DSR |
| bus_addr | input | 2 | Word address of the register port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 6 | Interrupt lines: combined, RX, TX, timeout, modem, error |

## Verification
A corrupted raw or mask register shows up on the register port in the very next cycle. It appears in the raw view and in the masked view, because these read the state directly. One cycle later it reaches the interrupt lines. A wrong group mapping shows only on the grouped lines, so the bench sweeps every mask value with all raw bits set. It also sweeps every event pattern with the mask fully open, so that each line is compared against its arithmetic expectation. Stale modem tracking is visible only across a sequence of software clears followed by level changes, and the bench drives exactly that sequence.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NBITS  = 11;
  localparam int NLINES = 6;

  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RT  = 6;
  localparam int B_FE  = 7;
  localparam int B_OE  = 10;

  localparam int OFF_MASK   = 0;
  localparam int OFF_RAW    = 1;
  localparam int OFF_MASKED = 2;
  localparam int OFF_CLEAR  = 3;

  // Group of raw bits that feeds each interrupt line
  function automatic logic [NBITS-1:0] line_group(input int idx);
    logic [NBITS-1:0] g;
    g = '0;
    case (idx)
      0:       g = '1;
      1:       g[B_RX] = 1'b1;
      2:       g[B_TX] = 1'b1;
      3:       g[B_RT] = 1'b1;
      4:       g[B_DSR:B_RI] = '1;
      default: g[B_OE:B_FE] = '1;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int NB = NBITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic [NB-1:0] clr_vec,
  input  logic [3:0]    modem_lvl,
  output logic [NB-1:0] raw_q,
  output logic [3:0]    lvl_q
);
  logic [NB-1:0] raw_n;
  logic          lvl_chg;
  logic          raw_en;

  always_comb begin
    lvl_chg = (modem_lvl != lvl_q);
    raw_n   = (raw_q & ~clr_vec) | set_vec;
    if (lvl_chg) raw_n[B_DSR:B_RI] = modem_lvl;
    raw_en  = lvl_chg | (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      lvl_q <= '0;
    end else begin
      if (raw_en)  raw_q <= raw_n;
      if (lvl_chg) lvl_q <= modem_lvl;
    end
  end
endmodule

// File: rtl/uart_irq_regport.sv
module uart_irq_regport
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int NB     = NBITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NB-1:0]     raw_q,
  output logic [NB-1:0]     mask_q,
  output logic [NB-1:0]     clr_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);

  logic          mask_en;
  logic [NB-1:0] mask_n;
  logic          unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:NB];

  always_comb begin
    mask_en = wr && (addr == A_MASK);
    mask_n  = wdata[NB-1:0];
    clr_vec = (wr && (addr == A_CLEAR)) ? wdata[NB-1:0] : '0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_MASK:   rdata = DATA_W'(mask_q);
      A_RAW:    rdata = DATA_W'(raw_q);
      A_MASKED: rdata = DATA_W'(raw_q & mask_q);
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_n;
  end
endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
  import uart_irq_pkg::*;
#(
  parameter int NB = NBITS,
  parameter int NL = NLINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] raw_q,
  input  logic [NB-1:0] mask_q,
  output logic [NL-1:0] irq_q
);
  logic [NB-1:0] masked;
  logic [NL-1:0] irq_n;

  assign masked = raw_q & mask_q;

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign irq_n[g] = |(masked & line_group(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_n;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx_trig,
  input  logic              ev_rx_below,
  input  logic              ev_tx_write,
  input  logic              ev_rx_timeout,
  input  logic [3:0]        ev_err,
  input  logic [3:0]        modem_lvl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NLINES-1:0] irq
);
  logic [NBITS-1:0] set_vec;
  logic [NBITS-1:0] clr_vec;
  logic [NBITS-1:0] port_clr;
  logic [NBITS-1:0] raw_q;
  logic [NBITS-1:0] mask_q;
  logic [3:0]       lvl_q;

  always_comb begin
    set_vec              = '0;
    set_vec[B_RX]        = ev_rx_trig;
    set_vec[B_TX]        = ev_tx_write;
    set_vec[B_RT]        = ev_rx_timeout;
    set_vec[B_OE:B_FE]   = ev_err;
    clr_vec              = port_clr;
    clr_vec[B_RX]        = port_clr[B_RX] | ev_rx_below;
  end

  uart_irq_status #(.NB(NBITS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .modem_lvl(modem_lvl),
    .raw_q    (raw_q),
    .lvl_q    (lvl_q)
  );

  uart_irq_regport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NB(NBITS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .raw_q  (raw_q),
    .mask_q (mask_q),
    .clr_vec(port_clr),
    .rdata  (bus_rdata)
  );

  uart_irq_lines #(.NB(NBITS), .NL(NLINES)) u_lines (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_q (raw_q),
    .mask_q(mask_q),
    .irq_q (irq)
  );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              ev_tx_write,
  input logic [3:0]        ev_err,
  input logic [3:0]        modem_lvl,
  input logic [NLINES-1:0] irq,
  input logic [NBITS-1:0]  raw,
  input logic [NBITS-1:0]  mask,
  input logic [3:0]        lvl_seen
);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> NBITS) == '0);

  a_r2_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_MASKED)) |-> bus_rdata == DATA_W'(raw & mask));

  a_r4_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_CLEAR) && ev_err == 4'd0)
    |=> (raw[B_OE:B_FE] & $past(bus_wdata[B_OE:B_FE])) == 4'd0);

  a_r8_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_write |=> raw[B_TX]);

  a_r6_line_all: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq[0] == $past(|(raw & mask)));

  a_r6_line_err: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq[5] == $past(|(raw[B_OE:B_FE] & mask[B_OE:B_FE])));

  a_r7_modem_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_lvl != lvl_seen) |=> raw[B_DSR:B_RI] == $past(modem_lvl));
endmodule

bind uart_irq_ctrl uart_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ev_tx_write(ev_tx_write),
  .ev_err     (ev_err),
  .modem_lvl  (modem_lvl),
  .irq        (irq),
  .raw        (raw_q),
  .mask       (mask_q),
  .lvl_seen   (lvl_q)
);

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_rx_trig, ev_rx_below, ev_tx_write, ev_rx_timeout;
  logic [3:0]  ev_err, modem_lvl;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_NS/2) clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ev_rx_trig(ev_rx_trig), .ev_rx_below(ev_rx_below),
    .ev_tx_write(ev_tx_write), .ev_rx_timeout(ev_rx_timeout), .ev_err(ev_err),
    .modem_lvl(modem_lvl), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 2'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 2'(a); bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  // Pulse events given as a raw-bit pattern (bits 4..10)
  task automatic pulse(input logic [10:0] v);
    ev_rx_trig = v[4]; ev_tx_write = v[5]; ev_rx_timeout = v[6]; ev_err = v[10:7];
    cyc();
    ev_rx_trig = 0; ev_tx_write = 0; ev_rx_timeout = 0; ev_err = 0;
  endtask

  function automatic logic [31:0] exp_irq(input logic [10:0] m);
    logic [5:0] e;
    e[0] = |m; e[1] = m[4]; e[2] = m[5]; e[3] = m[6];
    e[4] = |m[3:0]; e[5] = |m[10:7];
    return 32'(e);
  endfunction

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [10:0] cur_mask;
    rst_n = 0; ev_rx_trig = 0; ev_rx_below = 0; ev_tx_write = 0; ev_rx_timeout = 0;
    ev_err = 0; modem_lvl = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0;
    repeat (3) cyc();
    // R9 reset state
    rd(0, d); chk("R9 mask", d, 0);
    rd(1, d); chk("R9 raw", d, 0);
    chk("R9 irq", 32'(irq), 0);
    rst_n = 1;
    cyc();

    // R1 each event bit, R4 clear it
    for (int b = 4; b <= 10; b++) begin
      pulse(11'(1 << b));
      rd(1, d); chk("R1 event bit", d, 32'(1 << b));
      wr(3, 32'(1 << b));
      rd(1, d); chk("R4 clear", d, 0);
    end
    // R7 modem levels
    for (int b = 0; b < 4; b++) begin
      modem_lvl = 4'(1 << b); cyc();
      rd(1, d); chk("R7 modem set", d, 32'(1 << b));
      modem_lvl = 0; cyc();
      rd(1, d); chk("R7 modem drop", d, 0);
    end
    modem_lvl = 4'b0101; cyc();
    rd(1, d); chk("R7 two levels", d, 32'h5);
    wr(3, 32'h1);
    rd(1, d); chk("R7 cleared stays", d, 32'h4);
    cyc();
    rd(1, d); chk("R7 cleared stays later", d, 32'h4);
    modem_lvl = 4'b0111; cyc();
    rd(1, d); chk("R7 change resamples", d, 32'h7);
    modem_lvl = 0; cyc();
    rd(1, d); chk("R7 all low", d, 0);

    // R4 partial clear
    pulse(11'h7F0);
    wr(3, 32'hFFFF_F0A0);
    rd(1, d); chk("R4 partial", d, 32'h750);
    wr(3, 32'h7FF);

    // R11 below-trigger clear and set priority
    pulse(11'h010);
    ev_rx_below = 1; cyc(); ev_rx_below = 0;
    rd(1, d); chk("R11 below clears", d, 0);
    ev_rx_below = 1; ev_rx_trig = 1; cyc(); ev_rx_below = 0; ev_rx_trig = 0;
    rd(1, d); chk("R11 set wins", d, 32'h10);
    wr(3, 32'h7FF);

    // R8 set and clear write on same bit
    ev_tx_write = 1; bus_addr = 3; bus_wdata = 32'h20; bus_wr = 1;
    cyc();
    ev_tx_write = 0; bus_wr = 0;
    rd(1, d); chk("R8 set wins", d, 32'h20);

    // R5 writes to read-only views
    wr(0, 32'h155); cur_mask = 11'h155;
    wr(1, 32'h0); wr(1, 32'hFFFF_FFFF); wr(2, 32'h0); wr(2, 32'hFFFF_FFFF);
    rd(1, d); chk("R5 raw kept", d, 32'h20);
    rd(0, d); chk("R5 mask kept", d, 32'h155);

    // R3 upper bits and clear location
    wr(0, 32'hFFFF_FFFF); cur_mask = 11'h7FF;
    rd(0, d); chk("R3 mask upper zero", d, 32'h7FF);
    rd(3, d); chk("R3 clear reads zero", d, 0);

    // R2 / R6 / R10 sweep over every mask with all raw bits set
    modem_lvl = 4'hF; pulse(11'h7F0);
    rd(1, d); chk("R1 all set", d, 32'h7FF);
    for (int m = 0; m < 2048; m++) begin
      wr(0, 32'(m));
      chk("R10 irq lags mask", 32'(irq), exp_irq(cur_mask));
      cur_mask = 11'(m);
      rd(0, d); chk("R2 mask readback", d, 32'(m));
      rd(2, d); chk("R2 masked view", d, 32'(m));
      cyc();
      chk("R6 lines", 32'(irq), exp_irq(11'(m)));
    end

    // R1 / R6 sweep over event patterns with mask open
    wr(0, 32'h7FF);
    modem_lvl = 0; cyc();
    for (int r = 0; r < 128; r++) begin
      wr(3, 32'h7FF);
      pulse(11'(r << 4));
      rd(1, d); chk("R1 pattern", d, 32'(r << 4));
      rd(2, d); chk("R3 masked upper zero", d, 32'(r << 4));
      cyc();
      chk("R6 pattern lines", 32'(irq), exp_irq(11'(r << 4)));
    end

    // R9 reset again clears everything
    rst_n = 0; #1;
    rd(1, d); chk("R9 raw in reset", d, 0);
    rd(0, d); chk("R9 mask in reset", d, 0);
    chk("R9 irq in reset", 32'(irq), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule